// File: doc/BRIEF.md
# Parallel Flash Write Engine

This block sits on the host side of a byte-wide parallel flash bus and carries out one write operation per request: a byte program, an erase of one sector, or an erase of the whole device. After it issues the unlock and command write cycles, it polls the target location until the status bits report that the internal operation has finished. It then pulses `done`. If the status does not report completion before a cycle limit, it pulses `error` instead.

The bus is modelled as simple synchronous strobes. A one-cycle `bus_wr` carries an address and a data byte. A one-cycle `bus_rd` carries an address, and the flash returns its byte on `bus_rdata` in the following cycle. Two completion tests are offered. One compares bit 7 with the value it will hold when the operation is over. The other checks whether bit 6 has stopped alternating between two consecutive reads. A completion candidate found by either test is accepted only after two further reads confirm it. This stops a read that lands at the instant the operation ends from being taken as final.

The engine does not erase a sector before it programs a byte. The caller must issue an erase first.

Top module: `nvmw_engine`

## Requirements
- R1: A program request (`req_op` = 00) produces exactly 4 write cycles on consecutive clocks: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (request address, request data).
- R2: A sector erase request (`req_op` = 01) produces 6 consecutive write cycles: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), then 0x30 written to the request address with its low SECT_W bits cleared.
- R3: A chip erase request (`req_op` = 10 or 11) produces the same first five writes as R2 and ends with 0x10 written at 0x5555.
- R4: With `req_poll_b6` = 0, a read counts as complete when bit 7 equals the expected value: bit 7 of the request data for a program, and 1 for either erase. Every status read uses the request address.
- R5: With `req_poll_b6` = 1, a read counts as complete when its bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation is never complete.
- R6: The first complete read starts a confirmation. `done` pulses only after the next two reads are also complete. An incomplete read during the confirmation drops back to plain polling.
- R7: If completion is not confirmed within TMO_LIMIT cycles of the start of polling, `error` pulses for one cycle and the engine returns to idle.
- R8: A request is accepted only when `busy` is low. A request raised while busy is ignored, leaves the write sequence and the result unchanged, and pulses `req_drop` in the next cycle.
- R9: The polling method is taken from `req_poll_b6` in the accepting cycle. Later changes of that input have no effect on the running operation.
- R10: `busy` is high from the cycle after acceptance until the cycle in which `done` or `error` pulses, and it is low in that cycle.
- R11: After reset, `busy`, `done`, `error`, `req_drop`, `bus_wr` and `bus_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Byte to program |
| req_poll_b6 | input | 1 | 0: bit 7 polling, 1: bit 6 polling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation confirmed complete |
| error | output | 1 | One-cycle pulse: completion timeout |
| req_drop | output | 1 | One-cycle pulse: a request arrived while busy |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench builds the engine with ADDR_W = 18, SECT_W = 12 and TMO_LIMIT = 64. The short limit lets a flash that never finishes reach the timeout in a few dozen cycles. It also leaves enough room for operations that stay busy for several reads, which exercises both polling methods. The flash model in the bench can return one early "finished-looking" read in the middle of the busy phase. This shows that the two confirmation reads reject it. The 18-bit address with 4 KiB sectors makes the cleared low bits of a sector erase address visible.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10
  } nvm_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_WR   = 2'b01,
    S_RD   = 2'b10,
    S_EV   = 2'b11
  } nvm_state_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam int          CONFIRM_READS = 2;

  // raw two-bit code to operation; both codes with bit 1 set select chip erase
  function automatic nvm_op_e decode_op(input logic [1:0] raw);
    if (raw[1])      return OP_CHIP;
    else if (raw[0]) return OP_SECT;
    else             return OP_PROG;
  endfunction

  function automatic logic [2:0] seq_len(input nvm_op_e op);
    return (op == OP_PROG) ? 3'd4 : 3'd6;
  endfunction

  // code written in the third cycle
  function automatic logic [7:0] setup_code(input nvm_op_e op);
    return (op == OP_PROG) ? 8'hA0 : 8'h80;
  endfunction

  // code written in the last cycle of an erase
  function automatic logic [7:0] erase_code(input nvm_op_e op);
    return (op == OP_SECT) ? 8'h30 : 8'h10;
  endfunction

  // value bit 7 holds once the operation is over
  function automatic logic final_b7(input nvm_op_e op, input logic [7:0] data);
    return (op == OP_PROG) ? data[7] : 1'b1;
  endfunction

endpackage

// File: rtl/nvmw_cmd_seq.sv
module nvmw_cmd_seq
  import nvmw_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SECT_W = 12
) (
  input  nvm_op_e           op,
  input  logic [2:0]        idx,
  input  logic [ADDR_W-1:0] target,
  input  logic [7:0]        data,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(UNLOCK_B);

  logic [ADDR_W-1:0] sect_base;

  assign sect_base = {target[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
  assign last      = (idx == seq_len(op) - 3'd1);

  always_comb begin
    cmd_addr = ADR_A;
    cmd_data = KEY_A;
    case (idx)
      3'd0: begin cmd_addr = ADR_A; cmd_data = KEY_A; end
      3'd1: begin cmd_addr = ADR_B; cmd_data = KEY_B; end
      3'd2: begin cmd_addr = ADR_A; cmd_data = setup_code(op); end
      3'd3: begin
        if (op == OP_PROG) begin cmd_addr = target; cmd_data = data; end
        else               begin cmd_addr = ADR_A;  cmd_data = KEY_A; end
      end
      3'd4: begin cmd_addr = ADR_B; cmd_data = KEY_B; end
      3'd5: begin
        if (op == OP_SECT) cmd_addr = sect_base;
        else               cmd_addr = ADR_A;
        cmd_data = erase_code(op);
      end
      default: begin cmd_addr = ADR_A; cmd_data = KEY_A; end
    endcase
  end

endmodule

// File: rtl/nvmw_status_eval.sv
module nvmw_status_eval (
  input  logic       use_b6,
  input  logic       exp_b7,
  input  logic [7:0] rdata,
  input  logic       prev_b6,
  input  logic       have_prev,
  output logic       complete
);

  always_comb begin
    if (use_b6) complete = have_prev && (rdata[6] == prev_b6);
    else        complete = (rdata[7] == exp_b7);
  end

endmodule

// File: rtl/nvmw_timeout.sv
module nvmw_timeout #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1) + 1;
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear)                  cnt_q <= '0;
    else if (count_en && cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q >= LIM);

  a_r7_expiry_needs_counting: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(count_en));

endmodule

// File: rtl/nvmw_engine.sv
module nvmw_engine
  import nvmw_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int SECT_W    = 12,
  parameter int TMO_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_poll_b6,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              req_drop,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata
);

  localparam logic [1:0] CONF_FULL = 2'(CONFIRM_READS);

  nvm_state_e        state_q;
  nvm_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              b6_q;
  logic [2:0]        idx_q;
  logic [1:0]        conf_q;
  logic              prev_b6_q;
  logic              have_prev_q;
  logic              done_q, error_q, drop_q;

  // named internal events
  logic              accept;
  logic              seq_last;
  logic              st_complete;
  logic              finish_ok;
  logic              tmo_expired;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign finish_ok = (state_q == S_EV) && st_complete && (conf_q == CONF_FULL);

  nvmw_cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_seq (
    .op(op_q), .idx(idx_q), .target(addr_q), .data(data_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .last(seq_last)
  );

  nvmw_status_eval u_eval (
    .use_b6(b6_q), .exp_b7(final_b7(op_q, data_q)), .rdata(bus_rdata),
    .prev_b6(prev_b6_q), .have_prev(have_prev_q), .complete(st_complete)
  );

  nvmw_timeout #(.LIMIT(TMO_LIMIT)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == S_WR),
    .count_en((state_q == S_RD) || (state_q == S_EV)),
    .expired(tmo_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      b6_q        <= 1'b0;
      idx_q       <= '0;
      conf_q      <= '0;
      prev_b6_q   <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      error_q     <= 1'b0;
      drop_q      <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
      drop_q  <= req_valid && (state_q != S_IDLE);
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            op_q        <= decode_op(req_op);
            addr_q      <= req_addr;
            data_q      <= req_data;
            b6_q        <= req_poll_b6;
            idx_q       <= '0;
            conf_q      <= '0;
            have_prev_q <= 1'b0;
            state_q     <= S_WR;
          end
        end
        S_WR: begin
          if (seq_last) state_q <= S_RD;
          else          idx_q   <= idx_q + 3'd1;
        end
        S_RD: state_q <= S_EV;
        S_EV: begin
          prev_b6_q   <= bus_rdata[6];
          have_prev_q <= 1'b1;
          if (!st_complete)          conf_q <= '0;
          else if (conf_q != CONF_FULL) conf_q <= conf_q + 2'd1;
          if (finish_ok) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (tmo_expired) begin
            error_q <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign error     = error_q;
  assign req_drop  = drop_q;
  assign bus_wr    = (state_q == S_WR);
  assign bus_rd    = (state_q == S_RD);
  assign bus_addr  = bus_wr ? cmd_addr : addr_q;
  assign bus_wdata = bus_wr ? cmd_data : 8'h00;

  // R1/R2/R3: command writes come back to back until the sequence ends
  a_r1_writes_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !seq_last |=> bus_wr);
  a_r6_done_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(conf_q) == CONF_FULL);
  a_r7_error_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> $past(tmo_expired));
  a_r8_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy |=> req_drop);
  a_r8_busy_only_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  a_r10_result_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy);
  a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error}));

endmodule

// File: tb/nvmw_engine_test.sv
module nvmw_engine_test;

  localparam int AW  = 18;
  localparam int SW  = 12;
  localparam int TMO = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          req_poll_b6 = 1'b0;
  logic          busy, done, error, req_drop, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;

  nvmw_engine #(.ADDR_W(AW), .SECT_W(SW), .TMO_LIMIT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_poll_b6(req_poll_b6),
    .busy(busy), .done(done), .error(error), .req_drop(req_drop),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard for write cycles
  logic [AW+7:0] exp_q[$];
  string         tag_q[$];

  // flash model
  int     m_busy_left = 0;
  int     m_race = -1;
  int     m_rd_idx = 0;
  logic   m_tog = 1'b0;
  logic   m_prog = 1'b1;
  logic [7:0] m_data = 8'h00;
  int     m_post = 0;
  logic [AW-1:0] m_rd_addr = '0;
  longint first_rd = -1;
  bit     rd_addr_bad = 0;
  bit     drop_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (bus_rd) begin
      if (m_busy_left > 0) begin
        if (m_rd_idx == m_race)
          bus_rdata <= {(m_prog ? m_data[7] : 1'b1), m_tog, 6'b0};
        else begin
          bus_rdata <= {(m_prog ? ~m_data[7] : 1'b0), ~m_tog, 6'b0};
          m_tog = ~m_tog;
        end
        m_busy_left = m_busy_left - 1;
        m_rd_idx = m_rd_idx + 1;
      end else begin
        bus_rdata <= m_prog ? m_data : 8'hFF;
        m_post = m_post + 1;
      end
    end
  end

  // monitor: pops expected writes, watches reads and drop flags
  always @(negedge clk) begin
    if (rst_n && bus_wr) begin
      if (exp_q.size() == 0) chk(0, "R8", "unexpected write", {bus_addr, bus_wdata}, 0);
      else begin
        logic [AW+7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({bus_addr, bus_wdata} == e, t, "write cycle", {bus_addr, bus_wdata}, e);
      end
    end
    if (rst_n && bus_rd) begin
      if (first_rd < 0) first_rd = cyc;
      if (bus_addr != m_rd_addr) rd_addr_bad = 1;
    end
    if (req_drop) drop_seen = 1;
  end

  task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d, input string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] addr,
                        input logic [7:0] data, input logic sel, input int nbusy,
                        input int race, input int drop_at, input bit expect_err,
                        input string rq);
    bit got_done, got_err, saw_busy_low;
    longint err_cyc;
    int flips, exp_post;
    logic fin6;
    string seq_tag;
    got_done = 0; got_err = 0; saw_busy_low = 0; err_cyc = 0;
    @(negedge clk);
    m_busy_left = nbusy; m_race = race; m_rd_idx = 0; m_tog = 1'b0;
    m_prog = (op == 2'b00); m_data = data; m_post = 0; m_rd_addr = addr;
    first_rd = -1; rd_addr_bad = 0; drop_seen = 0;
    seq_tag = (op == 2'b00) ? "R1" : (op == 2'b01) ? "R2" : "R3";
    push_w(18'h05555, 8'hAA, seq_tag);
    push_w(18'h02AAA, 8'h55, seq_tag);
    if (op == 2'b00) begin
      push_w(18'h05555, 8'hA0, seq_tag);
      push_w(addr, data, seq_tag);
    end else begin
      push_w(18'h05555, 8'h80, seq_tag);
      push_w(18'h05555, 8'hAA, seq_tag);
      push_w(18'h02AAA, 8'h55, seq_tag);
      if (op == 2'b01) push_w({addr[AW-1:SW], {SW{1'b0}}}, 8'h30, seq_tag);
      else             push_w(18'h05555, 8'h10, seq_tag);
    end
    req_op = op; req_addr = addr; req_data = data; req_poll_b6 = sel; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_poll_b6 = ~sel;   // R9: later value must not matter
    req_op = 2'b10; req_addr = ~addr; req_data = ~data;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    for (int k = 0; k < 3000; k++) begin
      if (done) got_done = 1;
      if (error) begin got_err = 1; err_cyc = cyc; end
      if (done || error) begin saw_busy_low = !busy; break; end
      if (k == drop_at) req_valid = 1'b1;
      else              req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(saw_busy_low, "R10", "busy low with result", !saw_busy_low, 0);
    chk(!rd_addr_bad, "R4", "status read address", rd_addr_bad, 0);
    if (drop_at >= 0) chk(drop_seen, "R8", "drop flag", drop_seen, 1);
    if (expect_err) begin
      chk(got_err && !got_done, "R7", "timeout reported", {got_done, got_err}, 2'b01);
      chk(err_cyc - first_rd >= TMO && err_cyc - first_rd <= TMO + 3, "R7",
          "timeout latency", err_cyc - first_rd, TMO + 2);
    end else begin
      chk(got_done && !got_err, rq, "completion", {got_done, got_err}, 2'b10);
      if (sel == 1'b0) exp_post = 3;
      else begin
        flips = nbusy - ((race >= 0 && race < nbusy) ? 1 : 0);
        fin6 = (op == 2'b00) ? data[6] : 1'b1;
        exp_post = (nbusy > 0 && fin6 == flips[0]) ? 3 : 4;
      end
      chk(m_post == exp_post, (race >= 0) ? "R6" : rq, "reads after finish", m_post, exp_post);
    end
    chk(exp_q.size() == 0, seq_tag, "write count", exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({busy, done, error, req_drop, bus_wr, bus_rd} == 6'b0, "R11", "reset outputs",
        {busy, done, error, req_drop, bus_wr, bus_rd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, bus_wr, bus_rd} == 3'b0, "R11", "idle after reset", {busy, bus_wr, bus_rd}, 0);
    // R1/R4: program, bit 7 polling
    run_op(2'b00, 18'h01234, 8'h5A, 1'b0, 5, -1, -1, 0, "R4");
    // R6: early finished-looking read rejected, bit 7
    run_op(2'b00, 18'h00F0F, 8'hC3, 1'b0, 6, 2, -1, 0, "R6");
    // R2: sector erase, bit 7 expects 1
    run_op(2'b01, 18'h2ABCD, 8'h00, 1'b0, 4, -1, -1, 0, "R2");
    // R3/R5/R6: chip erase, bit 6 polling with a race read
    run_op(2'b11, 18'h00007, 8'h00, 1'b1, 7, 3, -1, 0, "R5");
    // R5/R9: program, bit 6 polling; select input flipped after accept
    run_op(2'b00, 18'h3FFFF, 8'h40, 1'b1, 4, -1, -1, 0, "R9");
    // R5: no busy reads at all
    run_op(2'b10, 18'h10000, 8'h00, 1'b1, 0, -1, -1, 0, "R5");
    // R8: request while busy is dropped
    run_op(2'b00, 18'h00100, 8'h99, 1'b0, 8, -1, 5, 0, "R8");
    run_op(2'b01, 18'h20FFF, 8'h00, 1'b1, 6, -1, 2, 0, "R8");
    // R7: never finishes
    run_op(2'b00, 18'h00200, 8'h11, 1'b0, 100000, -1, -1, 1, "R7");
    // R7: engine usable after a timeout
    run_op(2'b00, 18'h00201, 8'h22, 1'b0, 2, -1, -1, 0, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule